// File: doc/BRIEF.md
# Two-Overflow Watchdog Timer

This block is a register-mapped watchdog. A host reaches it over a plain register bus made of an address, a write strobe, write data and combinational read data. Software loads a 12-bit period value and sets an enable bit. From then on the block counts clock cycles in periods of `(N + 1) * 2^PSC_LOG2` cycles.

The first period that runs out raises a sticky interrupt. If a second period then runs out with no refresh in between, the block issues a one-cycle system reset request. It then starts counting again from zero. Software keeps the system alive by writing 1 to bit 0 of the interrupt/clear register. This clears the running count, the pending interrupt and the overflow tally in the same cycle.

Writes to the enable, period and elapsed-count registers pass through a fixed synchronisation delay of `SYNC_LAT` cycles before they take effect. Refresh writes bypass that delay.

Top module: `wdog_dual_ovf`

## Requirements
- R1: After reset the enable bit reads 0, the period register reads 0xFFF00000 (period field all ones), the elapsed count reads 0, the interrupt flag reads 0, and neither `irq_o` nor `sys_rst_req_o` is asserted.
- R2: The register offsets and encodings are fixed:
  - 0x0 is control, with bit 0 = enable.
  - 0x4 is the period, with the field in bits 31:20.
  - 0x8 is the elapsed cycle count within the present period, zero-extended.
  - 0xC is interrupt/clear, where bit 0 reads the pending-interrupt flag.
  - Any other address reads 0.
- R3: Bits 19:0 written to the period register are discarded and always read back as 0.
- R4: A write to 0x0, 0x4 or 0x8 sampled at clock edge E takes effect at edge E+SYNC_LAT. Before that edge, reads and counting still use the old value.
- R5: While enabled, the count advances by one per cycle. A period with field N spans `(N+1)*2^PSC_LOG2` cycles. The first overflow sets the interrupt flag, and `irq_o` reflects it. The flag stays set until a refresh or a reset request clears it.
- R6: A second overflow with no refresh after the first produces `sys_rst_req_o` for exactly one cycle. At that same edge the count returns to 0 and both the tally and the interrupt flag clear.
- R7: Writing 1 to bit 0 of 0xC clears the count, the tally and the interrupt flag at the very edge that samples the write. Writing 0 to that bit changes nothing.
- R8: While the enable bit is 0, the count and the tally are held at 0, no reset request is issued, and the interrupt flag keeps its value.
- R9: A delayed write to 0x8 loads the count (low bits of the write data). A count at or past the last cycle of the period overflows at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting and bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Byte offset of the register accessed |
| bus_we_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Combinational read data for `bus_addr_i` |
| irq_o | output | 1 | Pending first-overflow interrupt |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The embedded properties are checked on every cycle:
- the reset request is a single-cycle pulse;
- a reset request only follows a pending interrupt and only while enabled;
- a refresh empties the count and flag on the next cycle;
- the interrupt flag never drops except by refresh or reset request;
- the applied configuration only moves when a delayed write emerges.

Exact period lengths, the precise edge at which a delayed write lands, and the discarding of low period bits can only be shown by the bench. It drives scenarios against a cycle-level reference model that tracks pending writes in a queue. Holding the interrupt while disabled, and the lack of effect of a zero written to the clear bit, are also shown only by the bench.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // Register byte offsets (software-visible contract)
   localparam int unsigned WDOG_OFS_CTRL    = 32'h0;
   localparam int unsigned WDOG_OFS_PERIOD  = 32'h4;
   localparam int unsigned WDOG_OFS_ELAPSED = 32'h8;
   localparam int unsigned WDOG_OFS_INTCLR  = 32'hC;

   // Target of a delayed (synchronised) register write
   typedef enum logic [1:0] {
      CFG_CTRL    = 2'd0,
      CFG_PERIOD  = 2'd1,
      CFG_ELAPSED = 2'd2
   } cfg_sel_e;

endpackage

// File: rtl/wdog_wr_sync.sv
// Fixed-latency delay line for configuration writes.
module wdog_wr_sync
   import wdog_pkg::*;
#(
   parameter int unsigned LAT = 4,
   parameter int unsigned DW  = 32
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          in_vld_i,
   input  cfg_sel_e      in_sel_i,
   input  logic [DW-1:0] in_data_i,
   output logic          out_vld_o,
   output cfg_sel_e      out_sel_o,
   output logic [DW-1:0] out_data_o
);

   generate
      if (LAT == 0) begin : g_bypass
         assign out_vld_o  = in_vld_i;
         assign out_sel_o  = in_sel_i;
         assign out_data_o = in_data_i;
      end else begin : g_pipe
         logic [LAT-1:0] vld_q;
         cfg_sel_e       sel_q  [LAT];
         logic [DW-1:0]  data_q [LAT];

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               vld_q <= '0;
               for (int i = 0; i < LAT; i++) begin
                  sel_q[i]  <= CFG_CTRL;
                  data_q[i] <= '0;
               end
            end else begin
               vld_q[0]  <= in_vld_i;
               sel_q[0]  <= in_sel_i;
               data_q[0] <= in_data_i;
               for (int i = 1; i < LAT; i++) begin
                  vld_q[i]  <= vld_q[i-1];
                  sel_q[i]  <= sel_q[i-1];
                  data_q[i] <= data_q[i-1];
               end
            end
         end

         assign out_vld_o  = vld_q[LAT-1];
         assign out_sel_o  = sel_q[LAT-1];
         assign out_data_o = data_q[LAT-1];
      end
   endgenerate

endmodule

// File: rtl/wdog_cfg.sv
// Applied configuration: enable bit and period field.
module wdog_cfg #(
   parameter int unsigned       PW         = 12,
   parameter logic [PW-1:0]     PERIOD_RST = '1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          upd_en_i,
   input  logic          en_val_i,
   input  logic          upd_per_i,
   input  logic [PW-1:0] per_val_i,
   output logic          en_o,
   output logic [PW-1:0] period_o
);

   logic          en_q;
   logic [PW-1:0] period_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q     <= 1'b0;
         period_q <= PERIOD_RST;
      end else begin
         if (upd_en_i)  en_q     <= en_val_i;
         if (upd_per_i) period_q <= per_val_i;
      end
   end

   assign en_o     = en_q;
   assign period_o = period_q;

   // R4: configuration only changes when a delayed write emerges
   a_r4_cfg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!upd_en_i && !upd_per_i) |=> ($stable(en_q) && $stable(period_q)));

endmodule

// File: rtl/wdog_core.sv
// Prescaled period counter, overflow tally, interrupt flag and reset pulse.
module wdog_core #(
   parameter int unsigned PW       = 12,
   parameter int unsigned PSC_LOG2 = 20,
   localparam int unsigned CW      = PW + PSC_LOG2
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          en_i,
   input  logic [PW-1:0] period_i,
   input  logic          clr_i,
   input  logic          ld_i,
   input  logic [CW-1:0] ld_val_i,
   output logic [CW-1:0] cnt_o,
   output logic          irq_o,
   output logic          rst_req_o
);

   logic [CW-1:0] cnt_q;
   logic          tally_q;
   logic          irq_q;
   logic          rst_req_q;
   logic [CW-1:0] last_cnt;
   logic          wrap;

   // Last cycle of a period: (N+1)*2^PSC_LOG2 - 1
   generate
      if (PSC_LOG2 == 0) begin : g_noscale
         assign last_cnt = period_i;
      end else begin : g_scale
         assign last_cnt = {period_i, {PSC_LOG2{1'b1}}};
      end
   endgenerate

   assign wrap = (cnt_q >= last_cnt);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q     <= '0;
         tally_q   <= 1'b0;
         irq_q     <= 1'b0;
         rst_req_q <= 1'b0;
      end else if (clr_i) begin
         cnt_q     <= '0;
         tally_q   <= 1'b0;
         irq_q     <= 1'b0;
         rst_req_q <= 1'b0;
      end else if (!en_i) begin
         cnt_q     <= '0;
         tally_q   <= 1'b0;
         rst_req_q <= 1'b0;
      end else if (ld_i) begin
         cnt_q     <= ld_val_i;
         rst_req_q <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         if (!tally_q) begin
            tally_q   <= 1'b1;
            irq_q     <= 1'b1;
            rst_req_q <= 1'b0;
         end else begin
            tally_q   <= 1'b0;
            irq_q     <= 1'b0;
            rst_req_q <= 1'b1;
         end
      end else begin
         cnt_q     <= cnt_q + CW'(1);
         rst_req_q <= 1'b0;
      end
   end

   assign cnt_o     = cnt_q;
   assign irq_o     = irq_q;
   assign rst_req_o = rst_req_q;

   // R6: reset request lasts a single cycle
   a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_q |=> !rst_req_q);

   // R6: a reset request is preceded by a pending first-overflow interrupt
   a_r6_after_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_q |-> $past(irq_q));

   // R8: no reset request unless counting was enabled
   a_r8_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_q |-> $past(en_i));

   // R7: refresh empties count and flag
   a_r7_refresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0 && !irq_q && !rst_req_q));

   // R5: interrupt flag is sticky
   a_r5_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_q) |-> ($past(clr_i) || rst_req_q));

endmodule

// File: rtl/wdog_dual_ovf.sv
// Register-mapped watchdog: reset request after two consecutive overflows.
module wdog_dual_ovf
   import wdog_pkg::*;
#(
   parameter int unsigned                ADDR_W     = 4,
   parameter int unsigned                DATA_W     = 32,
   parameter int unsigned                PERIOD_W   = 12,
   parameter int unsigned                PSC_LOG2   = 20,
   parameter int unsigned                SYNC_LAT   = 4,
   parameter logic [PERIOD_W-1:0]        PERIOD_RST = '1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_we_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o,
   output logic              sys_rst_req_o
);

   localparam int unsigned CNT_W = PERIOD_W + PSC_LOG2;
   localparam int unsigned PER_LSB = DATA_W - PERIOD_W;

   initial begin
      assert (CNT_W <= DATA_W)
         else $error("count width %0d exceeds data width %0d", CNT_W, DATA_W);
      assert (ADDR_W >= 4)
         else $error("address width %0d too small for register map", ADDR_W);
      assert (PERIOD_W >= 1 && PERIOD_W < DATA_W)
         else $error("period width %0d out of range", PERIOD_W);
   end

   // Address decode
   logic hit_ctrl, hit_per, hit_ela, hit_int;
   assign hit_ctrl = (bus_addr_i == ADDR_W'(WDOG_OFS_CTRL));
   assign hit_per  = (bus_addr_i == ADDR_W'(WDOG_OFS_PERIOD));
   assign hit_ela  = (bus_addr_i == ADDR_W'(WDOG_OFS_ELAPSED));
   assign hit_int  = (bus_addr_i == ADDR_W'(WDOG_OFS_INTCLR));

   logic     wr_vld;
   cfg_sel_e wr_sel;
   logic     clr;

   assign wr_vld = bus_we_i && (hit_ctrl || hit_per || hit_ela);
   assign clr    = bus_we_i && hit_int && bus_wdata_i[0];

   always_comb begin
      if (hit_per)      wr_sel = CFG_PERIOD;
      else if (hit_ela) wr_sel = CFG_ELAPSED;
      else              wr_sel = CFG_CTRL;
   end

   // Synchronisation delay for configuration writes
   logic              s_vld;
   cfg_sel_e          s_sel;
   logic [DATA_W-1:0] s_data;

   wdog_wr_sync #(
      .LAT (SYNC_LAT),
      .DW  (DATA_W)
   ) u_sync (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .in_vld_i   (wr_vld),
      .in_sel_i   (wr_sel),
      .in_data_i  (bus_wdata_i),
      .out_vld_o  (s_vld),
      .out_sel_o  (s_sel),
      .out_data_o (s_data)
   );

   logic                en;
   logic [PERIOD_W-1:0] period;

   wdog_cfg #(
      .PW         (PERIOD_W),
      .PERIOD_RST (PERIOD_RST)
   ) u_cfg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .upd_en_i  (s_vld && s_sel == CFG_CTRL),
      .en_val_i  (s_data[0]),
      .upd_per_i (s_vld && s_sel == CFG_PERIOD),
      .per_val_i (s_data[DATA_W-1 -: PERIOD_W]),
      .en_o      (en),
      .period_o  (period)
   );

   logic [CNT_W-1:0] cnt;
   logic             irq;
   logic             rst_req;

   wdog_core #(
      .PW       (PERIOD_W),
      .PSC_LOG2 (PSC_LOG2)
   ) u_core (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en),
      .period_i  (period),
      .clr_i     (clr),
      .ld_i      (s_vld && s_sel == CFG_ELAPSED),
      .ld_val_i  (s_data[CNT_W-1:0]),
      .cnt_o     (cnt),
      .irq_o     (irq),
      .rst_req_o (rst_req)
   );

   // Read mux
   always_comb begin
      bus_rdata_o = '0;
      if (hit_ctrl)     bus_rdata_o = {{(DATA_W-1){1'b0}}, en};
      else if (hit_per) bus_rdata_o = {period, {PER_LSB{1'b0}}};
      else if (hit_ela) bus_rdata_o = DATA_W'(cnt);
      else if (hit_int) bus_rdata_o = {{(DATA_W-1){1'b0}}, irq};
   end

   assign irq_o         = irq;
   assign sys_rst_req_o = rst_req;

   // R3: low bits of the period register never read as non-zero
   a_r3_per_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_per |-> (bus_rdata_o[PER_LSB-1:0] == '0));

endmodule

// File: tb/tb_wdog_dual_ovf.sv
module tb_wdog_dual_ovf;

   localparam int P_PSC = 4;
   localparam int P_LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   logic        rst_req;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   wdog_dual_ovf #(
      .ADDR_W     (4),
      .DATA_W     (32),
      .PERIOD_W   (12),
      .PSC_LOG2   (P_PSC),
      .SYNC_LAT   (P_LAT),
      .PERIOD_RST (12'hFFF)
   ) dut (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .bus_addr_i    (bus_addr),
      .bus_we_i      (bus_we),
      .bus_wdata_i   (bus_wdata),
      .bus_rdata_o   (bus_rdata),
      .irq_o         (irq),
      .sys_rst_req_o (rst_req)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   int          m_en, m_per, m_cnt, m_tally, m_irq, m_rst;
   int          cyc;
   int          q_due[$];
   int          q_addr[$];
   logic [31:0] q_data[$];
   int          o_en, o_per, o_cnt, len, ldv, a_pop, d_due;
   bit          ld, clr;
   logic [31:0] d_pop;

   function automatic logic [31:0] model_rd(input logic [3:0] a);
      case (a)
         4'h0:    return 32'(m_en);
         4'h4:    return 32'(m_per) << 20;
         4'h8:    return 32'(m_cnt);
         4'hC:    return 32'(m_irq);
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = 0; m_per = 'hFFF; m_cnt = 0; m_tally = 0; m_irq = 0; m_rst = 0;
         cyc = 0;
         q_due.delete(); q_addr.delete(); q_data.delete();
      end else begin
         o_en = m_en; o_per = m_per; o_cnt = m_cnt;
         ld = 0; ldv = 0;
         while (q_due.size() > 0 && q_due[0] == cyc) begin
            d_due = q_due.pop_front();
            a_pop = q_addr.pop_front();
            d_pop = q_data.pop_front();
            if (a_pop == 0) m_en = int'(d_pop[0]);
            else if (a_pop == 4) m_per = int'(d_pop[31:20]);
            else begin ld = 1; ldv = int'(d_pop[15:0]); end
         end
         clr = bus_we && bus_addr == 4'hC && bus_wdata[0];
         len = (o_per + 1) << P_PSC;
         if (clr) begin
            m_cnt = 0; m_tally = 0; m_irq = 0; m_rst = 0;
         end else if (o_en == 0) begin
            m_cnt = 0; m_tally = 0; m_rst = 0;
         end else if (ld) begin
            m_cnt = ldv; m_rst = 0;
         end else if (o_cnt >= len - 1) begin
            m_cnt = 0;
            if (m_tally == 0) begin m_tally = 1; m_irq = 1; m_rst = 0; end
            else begin m_tally = 0; m_irq = 0; m_rst = 1; end
         end else begin
            m_cnt = o_cnt + 1; m_rst = 0;
         end
         if (bus_we && (bus_addr == 4'h0 || bus_addr == 4'h4 || bus_addr == 4'h8)) begin
            q_due.push_back(cyc + P_LAT);
            q_addr.push_back(int'(bus_addr));
            q_data.push_back(bus_wdata);
         end
         cyc++;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R5 irq vs model", {31'b0, irq}, 32'(m_irq));
         chk("R6 reset request vs model", {31'b0, rst_req}, 32'(m_rst));
         chk("R2 read data vs model", bus_rdata, model_rd(bus_addr));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      @(posedge clk); #1;
      bus_addr = a;
      @(negedge clk);
      v = bus_rdata;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R5 watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      int n, pulses;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      rd(4'h0, v); chk("R1 ctrl after reset", v, 32'h0);
      rd(4'h4, v); chk("R1 period after reset", v, 32'hFFF0_0000);
      rd(4'h8, v); chk("R1 elapsed after reset", v, 32'h0);
      rd(4'hC, v); chk("R1 int flag after reset", v, 32'h0);
      chk("R1 irq pin", {31'b0, irq}, 32'h0);
      chk("R1 reset pin", {31'b0, rst_req}, 32'h0);
      rd(4'h6, v); chk("R2 unmapped reads zero", v, 32'h0);

      // R3 + R4: period write with low garbage, latency of P_LAT edges
      wr(4'h4, 32'h001A_BCDE);
      bus_addr = 4'h4;
      for (int i = 0; i < P_LAT; i++) begin
         @(negedge clk);
         chk("R4 period not yet applied", bus_rdata, 32'hFFF0_0000);
      end
      @(negedge clk);
      chk("R3 period low bits discarded", bus_rdata, 32'h0010_0000);

      // R5 + R6: N=1 -> 32-cycle period
      wr(4'h0, 32'h1);
      bus_addr = 4'h0;
      n = 0;
      do begin @(negedge clk); n++; end while (bus_rdata[0] == 1'b0 && n < 20);
      chk("R4 enable lands after latency", 32'(n), 32'(P_LAT + 1));
      n = 0;
      while (!irq && n < 200) begin @(negedge clk); n++; end
      chk("R5 first overflow after 32 cycles", 32'(n), 32'd32);
      n = 0;
      while (!rst_req && n < 200) begin @(negedge clk); n++; end
      chk("R6 second overflow after 32 more cycles", 32'(n), 32'd32);
      @(negedge clk);
      chk("R6 reset request one cycle", {31'b0, rst_req}, 32'h0);
      chk("R6 irq cleared by reset request", {31'b0, irq}, 32'h0);

      // R7: refresh
      n = 0;
      while (!irq && n < 200) begin @(negedge clk); n++; end
      wr(4'hC, 32'h0);
      @(negedge clk);
      chk("R7 zero write keeps irq", {31'b0, irq}, 32'h1);
      wr(4'hC, 32'h1);
      bus_addr = 4'h8;
      @(negedge clk);
      chk("R7 refresh clears irq", {31'b0, irq}, 32'h0);
      chk("R7 refresh clears count", bus_rdata, 32'h0);
      pulses = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (rst_req) pulses++;
      end
      chk("R7 no reset after refresh", 32'(pulses), 32'h0);
      chk("R7 irq again after fresh period", {31'b0, irq}, 32'h1);

      // R9: elapsed load near period end
      wr(4'hC, 32'h1);
      wr(4'h8, 32'd30);
      n = 0;
      while (!irq && n < 100) begin @(negedge clk); n++; end
      chk("R9 loaded count overflows early", 32'(n), 32'(P_LAT + 3));

      // R8: disable with interrupt pending
      wr(4'h0, 32'h0);
      bus_addr = 4'h8;
      pulses = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (rst_req) pulses++;
      end
      chk("R8 no reset while disabled", 32'(pulses), 32'h0);
      chk("R8 count held at zero", bus_rdata, 32'h0);
      chk("R8 irq held while disabled", {31'b0, irq}, 32'h1);

      // R3 + R5 + R6: N=0 -> 16-cycle period
      wr(4'hC, 32'h1);
      wr(4'h4, 32'h000F_FFFF);
      rd(4'h4, v);
      repeat (P_LAT) @(negedge clk);
      rd(4'h4, v); chk("R3 all low bits discarded", v, 32'h0);
      wr(4'h0, 32'h1);
      n = 0;
      while (!irq && n < 200) begin @(negedge clk); n++; end
      n = 0;
      while (!rst_req && n < 200) begin @(negedge clk); n++; end
      chk("R6 16-cycle second overflow", 32'(n), 32'd16);
      @(negedge clk);
      chk("R6 pulse ends N=0", {31'b0, rst_req}, 32'h0);

      repeat (5) @(posedge clk);
      finish_run();
   end

endmodule